// File: doc/BRIEF.md
# Bit-Serial CRC-32 Frame Generator and Checker

This block computes the Ethernet CRC-32 one bit per clock. A frame opens with an `init` pulse, which loads the 32-bit register with all ones. Each qualified serial bit then enters the register from its high end while the register moves toward bit 0, with polynomial feedback applied. The first bit is the first bit of the destination address. Preamble bits are never presented.

In transmit use, raising `mode_shift` ends accumulation. The same register then acts as a plain right shifter with feedback forced to zero. For 32 cycles it emits the inverted register contents, LSB first, as the frame check sequence, under an `out_valid` strobe. No separate output register is used.

In receive use, the data and the received check sequence both go through the calculation. An `eof` strobe then compares the result with the fixed good-frame residue and latches `crc_ok`. A node instantiates the block twice, one for transmit and one for receive, so it can check its own frames at the same time. The register is visible in parallel on `crc_state`, where an address hash filter reads bits [31:26] once the 48 destination-address bits have gone in.

Sequencer states and transitions: `ST_IDLE` (register frozen), `ST_ACCUM` (folding in bits), `ST_SHIFT` (serializing the check word).
- `init` moves any state to `ST_ACCUM`.
- `eof` moves `ST_ACCUM` to `ST_IDLE`.
- `mode_shift` moves `ST_ACCUM` to `ST_SHIFT`.
- The 32nd output bit moves `ST_SHIFT` to `ST_IDLE`.

Top module: `crc32_serial_engine`

## Requirements
- R1: While reset is asserted and just after it is released, `crc_state` is 32'hFFFFFFFF, `out_valid` is 0 and `crc_ok` is 0, and the sequencer is idle.
- R2: A cycle with `init` high sets `crc_state` to 32'hFFFFFFFF on the next edge, enters accumulation and clears `crc_ok`. It takes priority over every other input and state, and it aborts a shift-out in progress: `out_valid` is 0 from the next cycle.
- R3: In accumulation, each cycle with `data_valid`=1 and `mode_shift`=0 folds `din` in. The next value is the register shifted right by one with 0 entering bit 31, XORed with 32'hEDB88320 when bit 0 XOR `din` is 1. Bytes are presented LSB first. After the ASCII bytes "123456789", `crc_state` is 32'h340BC6D9.
- R4: In accumulation, a cycle with `data_valid`=0 leaves `crc_state` unchanged.
- R5: `mode_shift` high in accumulation starts shift-out on the next edge. For exactly 32 cycles `out_valid` is 1. `dout` carries the inverted register bits, bit 0 first, so the emitted word equals the bitwise complement of the register at entry; for "123456789" it is 32'hCBF43926. Zeros fill from bit 31, so `crc_state` is 0 afterwards. `dout` is 0 whenever `out_valid` is 0.
- R6: While idle, `din`, `data_valid`, `mode_shift` and `eof` have no effect: `crc_state`, `out_valid` and `crc_ok` hold.
- R7: `eof` in accumulation returns the block to idle and latches `crc_ok`=1 exactly when the register value after that cycle's update equals 32'hDEBB20E3. That value is the bit-reversed form of the 0xC704DD7B residue. `crc_ok` then holds until `init` or reset.
- R8: A frame whose check sequence has any single bit inverted yields `crc_ok`=0 at `eof`.
- R9: Two instances run concurrently without interaction. A receiver fed the transmitter's `dout` bit for bit, qualified by its `out_valid`, after the same data reports `crc_ok`=1.
- R10: After the 48th accumulated bit, `crc_state[31:26]` equals the top six bits of the CRC register computed over those 48 bits. This is the hash index, with bit 31 as its most significant bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| init | input | 1 | Frame start: preset register, enter accumulation |
| mode_shift | input | 1 | End accumulation and serialize the check word |
| data_valid | input | 1 | Qualifies `din` during accumulation |
| din | input | 1 | Serial data bit |
| eof | input | 1 | End-of-frame strobe for the residue comparison |
| dout | output | 1 | Serial check-sequence bit |
| out_valid | output | 1 | High during the 32 shift-out cycles |
| crc_ok | output | 1 | Latched residue-match result |
| crc_state | output | 32 | Parallel view of the CRC register |

## Verification
Several properties are checked on every clock:
- The register preset after `init`.
- The zero fill into bit 31 while serializing.
- The frozen register in the idle state.
- Shift-out beginning only after a `mode_shift` request.
- `crc_ok` rising only after `eof`.

Other behaviours show only in the bench's scenarios:
- The arithmetic of the fold against known check words.
- The exact 32-bit length and bit order of the emitted word.
- The hash-tap value.
- Loopback acceptance into a second instance and rejection of a corrupted check word.

// File: rtl/crc32_pkg.sv
package crc32_pkg;

    localparam int          CRC_W        = 32;
    localparam logic [31:0] POLY_REFL    = 32'hEDB88320;
    localparam logic [31:0] GOOD_RESIDUE = 32'hDEBB20E3;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ACCUM,
        ST_SHIFT
    } seq_state_e;

    typedef struct packed {
        logic preset;
        logic step;
        logic feed;
    } core_ctrl_t;

endpackage

// File: rtl/crc32_shift_core.sv
module crc32_shift_core
    import crc32_pkg::*;
#(
    parameter int           W    = CRC_W,
    parameter logic [W-1:0] POLY = POLY_REFL
) (
    input  logic         clk,
    input  logic         rst_n,
    input  core_ctrl_t   ctrl,
    input  logic         din,
    output logic [W-1:0] crc_q,
    output logic [W-1:0] crc_d
);

    logic fb;

    always_comb begin
        fb    = ctrl.feed & (crc_q[0] ^ din);
        crc_d = crc_q;
        if (ctrl.preset) begin
            crc_d = '1;
        end else if (ctrl.step) begin
            crc_d = {1'b0, crc_q[W-1:1]} ^ (fb ? POLY : '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc_q <= '1;
        end else begin
            crc_q <= crc_d;
        end
    end

    AST_PRESET_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.preset |=> (&crc_q)); // R2

    AST_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.step && !ctrl.feed && !ctrl.preset) |=> (crc_q[W-1] == 1'b0)); // R5

endmodule

// File: rtl/crc32_seq_fsm.sv
module crc32_seq_fsm
    import crc32_pkg::*;
#(
    parameter int W = CRC_W
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       init,
    input  logic       data_valid,
    input  logic       mode_shift,
    input  logic       eof,
    input  logic       residue_hit,
    output core_ctrl_t ctrl,
    output logic       out_valid,
    output logic       idle,
    output logic       crc_ok
);

    localparam int             CNT_W = $clog2(W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

    seq_state_e       st, st_n;
    logic [CNT_W-1:0] cnt;

    // state register, shift counter and result flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            cnt    <= '0;
            crc_ok <= 1'b0;
        end else begin
            st <= st_n;
            if (st == ST_SHIFT && !init) begin
                cnt <= cnt + 1'b1;
            end else begin
                cnt <= '0;
            end
            if (init) begin
                crc_ok <= 1'b0;
            end else if (st == ST_ACCUM && eof) begin
                crc_ok <= residue_hit;
            end
        end
    end

    // next state
    always_comb begin
        st_n = st;
        unique case (st)
            ST_IDLE:  st_n = ST_IDLE;
            ST_ACCUM: begin
                if (eof) begin
                    st_n = ST_IDLE;
                end else if (mode_shift) begin
                    st_n = ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                if (cnt == LAST) begin
                    st_n = ST_IDLE;
                end
            end
            default:  st_n = ST_IDLE;
        endcase
        if (init) begin
            st_n = ST_ACCUM;
        end
    end

    // outputs
    always_comb begin
        ctrl.preset = init;
        ctrl.feed   = (st == ST_ACCUM);
        ctrl.step   = 1'b0;
        out_valid   = 1'b0;
        idle        = 1'b0;
        unique case (st)
            ST_IDLE:  idle = 1'b1;
            ST_ACCUM: ctrl.step = data_valid & ~mode_shift & ~init;
            ST_SHIFT: begin
                ctrl.step = ~init;
                out_valid = 1'b1;
            end
            default:  idle = 1'b1;
        endcase
    end

    AST_SHIFT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(mode_shift)); // R5

    AST_OK_NEEDS_EOF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(crc_ok) |-> $past(eof)); // R7

    AST_INIT_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
        init |=> !out_valid); // R2

endmodule

// File: rtl/crc32_serial_engine.sv
module crc32_serial_engine
    import crc32_pkg::*;
#(
    parameter int           W       = CRC_W,
    parameter logic [W-1:0] POLY    = POLY_REFL,
    parameter logic [W-1:0] RESIDUE = GOOD_RESIDUE
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         init,
    input  logic         mode_shift,
    input  logic         data_valid,
    input  logic         din,
    input  logic         eof,
    output logic         dout,
    output logic         out_valid,
    output logic         crc_ok,
    output logic [W-1:0] crc_state
);

    core_ctrl_t   ctrl;
    logic [W-1:0] crc_d;
    logic         residue_hit;
    logic         seq_idle;

    assign residue_hit = (crc_d == RESIDUE);

    crc32_seq_fsm #(
        .W (W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .init        (init),
        .data_valid  (data_valid),
        .mode_shift  (mode_shift),
        .eof         (eof),
        .residue_hit (residue_hit),
        .ctrl        (ctrl),
        .out_valid   (out_valid),
        .idle        (seq_idle),
        .crc_ok      (crc_ok)
    );

    crc32_shift_core #(
        .W    (W),
        .POLY (POLY)
    ) u_core (
        .clk   (clk),
        .rst_n (rst_n),
        .ctrl  (ctrl),
        .din   (din),
        .crc_q (crc_state),
        .crc_d (crc_d)
    );

    assign dout = out_valid & ~crc_state[0];

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_idle && !init) |=> $stable(crc_state)); // R6

    AST_DOUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !dout); // R5

endmodule

// File: tb/test_crc32_serial_engine.sv
module test_crc32_serial_engine;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n;
    logic        t_init, t_shift, t_valid, t_din, t_eof, t_dout, t_ov, t_ok;
    logic        r_init, r_shift, r_valid, r_din, r_eof, r_dout, r_ov, r_ok;
    logic [31:0] t_crc, r_crc;

    int checks = 0;
    int errors = 0;

    crc32_serial_engine i_crc32_serial_engine (
        .clk(clk), .rst_n(rst_n), .init(t_init), .mode_shift(t_shift),
        .data_valid(t_valid), .din(t_din), .eof(t_eof), .dout(t_dout),
        .out_valid(t_ov), .crc_ok(t_ok), .crc_state(t_crc));

    crc32_serial_engine i_crc32_serial_engine_rx (
        .clk(clk), .rst_n(rst_n), .init(r_init), .mode_shift(r_shift),
        .data_valid(r_valid), .din(r_din), .eof(r_eof), .dout(r_dout),
        .out_valid(r_ov), .crc_ok(r_ok), .crc_state(r_crc));

    localparam int NV = 4;
    localparam logic [95:0] VDATA [NV] = '{
        96'h393837363534333231, 96'h00, 96'hFFFFFFFFFFFF,
        96'hA5C30F1E2D3C4B5A69788796};
    localparam int VLEN [NV] = '{9, 1, 6, 12};
    localparam logic [31:0] VFCS [NV] = '{32'hCBF43926, 32'h0, 32'h0, 32'h0};
    localparam bit VKNOWN [NV] = '{1'b1, 1'b0, 1'b0, 1'b0};

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mstep(input logic [31:0] c, input logic b);
        return (c >> 1) ^ ((c[0] ^ b) ? 32'hEDB88320 : 32'h0);
    endfunction

    task automatic tick;
        @(negedge clk);
    endtask

    task automatic run_frame(input logic [95:0] data, input int len,
                             input bit corrupt, output logic [31:0] fcs);
        logic [31:0] m;
        m = 32'hFFFFFFFF;
        t_init = 1'b1; r_init = 1'b1;
        tick;
        t_init = 1'b0; r_init = 1'b0;
        for (int i = 0; i < len * 8; i++) begin
            t_din = data[i]; t_valid = 1'b1;
            r_din = data[i]; r_valid = 1'b1;
            m = mstep(m, data[i]);
            tick;
            if (i == 47)
                check(t_crc[31:26] == m[31:26], "R10 hash tap",
                      {26'd0, t_crc[31:26]}, {26'd0, m[31:26]});
        end
        t_valid = 1'b0; r_valid = 1'b0;
        check(t_crc == m, "R3 accumulated register", t_crc, m);
        t_shift = 1'b1;
        tick;
        t_shift = 1'b0;
        for (int k = 0; k < 32; k++) begin
            check(t_ov == 1'b1, "R5 out_valid during shift", {31'd0, t_ov}, 32'd1);
            fcs[k] = t_dout;
            r_din = t_dout ^ (corrupt && k == 3);
            r_valid = 1'b1;
            tick;
        end
        r_valid = 1'b0;
        check(t_ov == 1'b0, "R5 out_valid after 32 bits", {31'd0, t_ov}, 32'd0);
        check(t_dout == 1'b0, "R5 dout quiet", {31'd0, t_dout}, 32'd0);
        check(t_crc == 32'h0, "R5 register drained", t_crc, 32'h0);
        check(fcs == ~m, "R5 emitted word", fcs, ~m);
        r_eof = 1'b1;
        tick;
        r_eof = 1'b0;
        if (corrupt)
            check(r_ok == 1'b0, "R8 corrupted frame rejected", {31'd0, r_ok}, 32'd0);
        else
            check(r_ok == 1'b1, "R7 R9 loopback accepted", {31'd0, r_ok}, 32'd1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] fcs, m, snap;
        rst_n = 1'b0;
        {t_init, t_shift, t_valid, t_din, t_eof} = '0;
        {r_init, r_shift, r_valid, r_din, r_eof} = '0;
        repeat (3) tick;
        check(t_crc == 32'hFFFFFFFF, "R1 reset register", t_crc, 32'hFFFFFFFF);
        rst_n = 1'b1;
        tick;
        check(t_crc == 32'hFFFFFFFF, "R1 register after release", t_crc, 32'hFFFFFFFF);
        check(t_ov == 1'b0 && t_ok == 1'b0, "R1 outputs low", {30'd0, t_ov, t_ok}, 32'd0);

        for (int v = 0; v < NV; v++) begin
            run_frame(VDATA[v], VLEN[v], 1'b0, fcs);
            if (VKNOWN[v])
                check(fcs == VFCS[v], "R3 R5 known check word", fcs, VFCS[v]);
        end

        // R6: inputs while idle on both instances
        snap = r_crc;
        t_valid = 1'b1; t_din = 1'b1; t_eof = 1'b1; t_shift = 1'b1;
        r_valid = 1'b1; r_din = 1'b0; r_eof = 1'b1; r_shift = 1'b1;
        repeat (4) tick;
        {t_valid, t_din, t_eof, t_shift} = '0;
        {r_valid, r_din, r_eof, r_shift} = '0;
        tick;
        check(t_crc == 32'h0, "R6 idle register frozen", t_crc, 32'h0);
        check(t_ov == 1'b0, "R6 no shift from idle", {31'd0, t_ov}, 32'd0);
        check(r_crc == snap, "R6 rx register frozen", r_crc, snap);
        check(r_ok == 1'b1, "R6 crc_ok held", {31'd0, r_ok}, 32'd1);

        // R2: init clears crc_ok
        r_init = 1'b1;
        tick;
        r_init = 1'b0;
        check(r_ok == 1'b0, "R2 init clears crc_ok", {31'd0, r_ok}, 32'd0);
        check(r_crc == 32'hFFFFFFFF, "R2 init presets rx", r_crc, 32'hFFFFFFFF);

        // R4: data_valid gaps
        t_init = 1'b1;
        tick;
        t_init = 1'b0;
        m = 32'hFFFFFFFF;
        for (int i = 0; i < 3; i++) begin
            t_din = i[0]; t_valid = 1'b1;
            m = mstep(m, i[0]);
            tick;
        end
        t_valid = 1'b0; t_din = 1'b1;
        for (int i = 0; i < 3; i++) begin
            tick;
            check(t_crc == m, "R4 gap holds register", t_crc, m);
        end

        // R2: init aborts a shift-out
        t_shift = 1'b1;
        tick;
        t_shift = 1'b0;
        repeat (5) tick;
        check(t_ov == 1'b1, "R5 shifting before abort", {31'd0, t_ov}, 32'd1);
        t_init = 1'b1;
        tick;
        t_init = 1'b0;
        check(t_ov == 1'b0, "R2 abort stops shift", {31'd0, t_ov}, 32'd0);
        check(t_crc == 32'hFFFFFFFF, "R2 abort presets", t_crc, 32'hFFFFFFFF);

        // R8: single inverted check bit
        run_frame(VDATA[3], VLEN[3], 1'b1, fcs);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule